// File: doc/BRIEF.md
# Device Mode Controller with Software Soft Reset

This block keeps the operating mode of the device and interprets software writes to a two-bit mode-control field. Three of the four field values pick a target mode directly (Normal, Stop, Sleep). The fourth value, 2'b11, is a soft-reset command. The command is honoured only while the device sits in Normal or Stop. When it is honoured, the mode returns to Init and a one-cycle pulse tells the register file to reload every control register with its default value. A soft reset never drives the external reset request.

Two hardware events also move the mode. A fault input forces Fail-Safe from any mode, and it wins over any write made in the same cycle. A wake input takes the device from Sleep or Fail-Safe into Restart. The external reset request is asserted for exactly as long as the mode is Restart. The write port is a plain strobe with no back-pressure: the block takes every strobed write in the cycle it appears, either applying it or dropping it.

Top module: `srm_mode_ctrl`

## Requirements
- R1: After reset `mode_o` is Init (0), and `cfg_default_o` and `reset_req_o` are both low. Mode codes: Init=0, Normal=1, Stop=2, Sleep=3, Restart=4, Fail-Safe=5.
- R2: A write with field 2'b11 while the mode is Normal or Stop, and no fault, sets the mode to Init at the clock edge that samples the write.
- R3: A write with field 2'b11 in Init, Sleep, Restart or Fail-Safe is ignored. The mode stays the same and no default pulse is produced.
- R4: An accepted soft reset raises `cfg_default_o` for exactly one cycle, starting at the same edge that moves the mode to Init. A second 2'b11 write in the following cycle gives no further pulse.
- R5: `reset_req_o` is high exactly while the mode is Restart. A soft reset never raises it.
- R6: Write fields 2'b00, 2'b10 and 2'b01 select Normal, Stop and Sleep respectively. They are applied in Init, Normal, Stop and Restart, and ignored in Sleep and Fail-Safe.
- R7: `hw_fault_i` high moves the mode to Fail-Safe at the next edge, overriding any write or wake in the same cycle. A soft reset that coincides with a fault gives no default pulse.
- R8: `wake_i` high in Sleep or Fail-Safe, with no fault, moves the mode to Restart at the next edge. In every other mode it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Mode-field write strobe |
| wr_field_i | input | 2 | Written mode field (2'b11 = soft reset) |
| hw_fault_i | input | 1 | Fault that forces Fail-Safe |
| wake_i | input | 1 | Wake event out of Sleep or Fail-Safe |
| mode_o | output | 3 | Current mode code |
| cfg_default_o | output | 1 | One-cycle register-default pulse |
| reset_req_o | output | 1 | External reset request |

## Verification
Every result is registered once. A stimulus applied before a rising edge shows on `mode_o`, `cfg_default_o` and `reset_req_o` just after that edge, so each result is due one cycle later. The driver applies stimulus on the falling edge and queues the expected triple. The monitor pops that triple one time unit after the following rising edge and compares all three outputs. Because of this, an ignored write, a stable mode and a missing or extra pulse are all seen in the very cycle in which they are due.

// File: rtl/srm_pkg.sv
package srm_pkg;
  localparam int MODE_W  = 3;
  localparam int FIELD_W = 2;

  typedef enum logic [MODE_W-1:0] {
    M_INIT     = 3'd0,
    M_NORMAL   = 3'd1,
    M_STOP     = 3'd2,
    M_SLEEP    = 3'd3,
    M_RESTART  = 3'd4,
    M_FAILSAFE = 3'd5
  } mode_e;

  localparam logic [FIELD_W-1:0] F_NORMAL = 2'b00;
  localparam logic [FIELD_W-1:0] F_SLEEP  = 2'b01;
  localparam logic [FIELD_W-1:0] F_STOP   = 2'b10;
  localparam logic [FIELD_W-1:0] F_SOFTRST = 2'b11;
endpackage

// File: rtl/srm_cmd_decode.sv
module srm_cmd_decode
  import srm_pkg::*;
(
  input  logic               wr_en,
  input  logic [FIELD_W-1:0] wr_field,
  input  mode_e              mode_q,
  output logic               soft_ok,
  output logic               set_ok,
  output mode_e              set_target
);
  logic soft_allowed;
  logic set_allowed;

  always_comb begin
    soft_allowed = (mode_q == M_NORMAL) || (mode_q == M_STOP);
    set_allowed  = (mode_q == M_INIT) || (mode_q == M_NORMAL) ||
                   (mode_q == M_STOP) || (mode_q == M_RESTART);
    soft_ok    = wr_en && (wr_field == F_SOFTRST) && soft_allowed;
    set_ok     = wr_en && (wr_field != F_SOFTRST) && set_allowed;
    unique case (wr_field)
      F_NORMAL: set_target = M_NORMAL;
      F_STOP:   set_target = M_STOP;
      F_SLEEP:  set_target = M_SLEEP;
      default:  set_target = M_INIT;
    endcase
  end
endmodule

// File: rtl/srm_mode_fsm.sv
module srm_mode_fsm
  import srm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hw_fault,
  input  logic               wake,
  input  logic               soft_ok,
  input  logic               set_ok,
  input  mode_e              set_target,
  input  logic               wr_en,
  input  logic [FIELD_W-1:0] wr_field,
  output mode_e              mode_q
);
  mode_e mode_d;
  logic  wake_ok;

  always_comb begin
    wake_ok = wake && ((mode_q == M_SLEEP) || (mode_q == M_FAILSAFE));
    mode_d  = mode_q;
    if (hw_fault)     mode_d = M_FAILSAFE;
    else if (wake_ok) mode_d = M_RESTART;
    else if (soft_ok) mode_d = M_INIT;
    else if (set_ok)  mode_d = set_target;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= M_INIT;
    else        mode_q <= mode_d;
  end

  // R2: accepted soft reset lands in Init
  p_softrst_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_field == F_SOFTRST && !hw_fault &&
     (mode_q == M_NORMAL || mode_q == M_STOP)) |=> (mode_q == M_INIT));

  // R3: soft reset elsewhere leaves mode alone
  p_softrst_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_field == F_SOFTRST && !hw_fault && !wake &&
     mode_q != M_NORMAL && mode_q != M_STOP) |=> $stable(mode_q));

  // R7: fault wins
  p_fault_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hw_fault |=> (mode_q == M_FAILSAFE));

  // R8: wake out of Sleep or Fail-Safe
  p_wake_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !hw_fault && (mode_q == M_SLEEP || mode_q == M_FAILSAFE))
      |=> (mode_q == M_RESTART));
endmodule

// File: rtl/srm_default_pulse.sv
module srm_default_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_ok,
  input  logic hw_fault,
  output logic pulse_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= soft_ok && !hw_fault;
  end

  // R4: the pulse never lasts two cycles
  p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
endmodule

// File: rtl/srm_mode_ctrl.sv
module srm_mode_ctrl
  import srm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [FIELD_W-1:0] wr_field_i,
  input  logic               hw_fault_i,
  input  logic               wake_i,
  output logic [MODE_W-1:0]  mode_o,
  output logic               cfg_default_o,
  output logic               reset_req_o
);
  mode_e mode_q;
  mode_e set_target;
  logic  soft_ok;
  logic  set_ok;

  srm_cmd_decode u_dec (
    .wr_en      (wr_en_i),
    .wr_field   (wr_field_i),
    .mode_q     (mode_q),
    .soft_ok    (soft_ok),
    .set_ok     (set_ok),
    .set_target (set_target)
  );

  srm_mode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .hw_fault   (hw_fault_i),
    .wake       (wake_i),
    .soft_ok    (soft_ok),
    .set_ok     (set_ok),
    .set_target (set_target),
    .wr_en      (wr_en_i),
    .wr_field   (wr_field_i),
    .mode_q     (mode_q)
  );

  srm_default_pulse u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_ok  (soft_ok),
    .hw_fault (hw_fault_i),
    .pulse_q  (cfg_default_o)
  );

  assign mode_o      = mode_q;
  assign reset_req_o = (mode_q == M_RESTART);

  // R5: soft reset never comes with a reset request
  p_no_reset_on_soft_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_default_o |-> !reset_req_o);

  // R4: pulse coincides with arrival in Init
  p_pulse_in_init_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_default_o |-> (mode_o == M_INIT));
endmodule

// File: tb/srm_mode_ctrl_test.sv
module srm_mode_ctrl_test;
  typedef struct {
    logic [2:0] mode;
    logic       pulse;
    logic       rreq;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_field = 2'b00;
  logic       fault = 1'b0;
  logic       wake = 1'b0;
  logic [2:0] mode;
  logic       pulse;
  logic       rreq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;

  srm_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_field_i(wr_field),
    .hw_fault_i(fault), .wake_i(wake), .mode_o(mode),
    .cfg_default_o(pulse), .reset_req_o(rreq)
  );

  localparam logic [2:0] INIT = 0, NORM = 1, STOP = 2, SLP = 3, RST = 4, FS = 5;

  task automatic compare(input exp_t e);
    total++;
    if (mode !== e.mode || pulse !== e.pulse || rreq !== e.rreq) begin
      bad++;
      $display("FAIL %s: got mode=%0d pulse=%b rreq=%b exp mode=%0d pulse=%b rreq=%b",
               e.tag, mode, pulse, rreq, e.mode, e.pulse, e.rreq);
    end
  endtask

  task automatic step(input logic we, input logic [1:0] f, input logic flt,
                      input logic wk, input logic [2:0] em, input logic ep,
                      input string tag);
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_field = f; fault = flt; wake = wk;
    e.mode = em; e.pulse = ep; e.rreq = (em == RST); e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) compare(q.pop_front());
    end
  end

  initial begin : watchdog
    repeat (2000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    exp_t r;
    repeat (3) @(posedge clk);
    #1;
    r.mode = INIT; r.pulse = 0; r.rreq = 0; r.tag = "R1 reset state";
    compare(r);
    @(negedge clk) rst_n = 1'b1;
    step(1, 2'b11, 0, 0, INIT, 0, "R3 softrst in Init ignored");
    step(1, 2'b00, 0, 0, NORM, 0, "R6 write Normal");
    step(1, 2'b11, 0, 0, INIT, 1, "R2 R4 softrst from Normal");
    step(0, 2'b00, 0, 0, INIT, 0, "R4 pulse drops");
    step(1, 2'b10, 0, 0, STOP, 0, "R6 write Stop");
    step(1, 2'b11, 0, 0, INIT, 1, "R2 softrst from Stop");
    step(1, 2'b11, 0, 0, INIT, 0, "R4 back-to-back no second pulse");
    step(1, 2'b01, 0, 0, SLP,  0, "R6 write Sleep");
    step(1, 2'b11, 0, 0, SLP,  0, "R3 softrst in Sleep ignored");
    step(1, 2'b00, 0, 0, SLP,  0, "R6 write ignored in Sleep");
    step(0, 2'b00, 0, 1, RST,  0, "R8 wake from Sleep");
    step(1, 2'b11, 0, 0, RST,  0, "R3 R5 softrst in Restart ignored");
    step(1, 2'b00, 0, 0, NORM, 0, "R6 R5 Restart to Normal");
    step(0, 2'b00, 0, 1, NORM, 0, "R8 wake ignored in Normal");
    step(1, 2'b11, 1, 0, FS,   0, "R7 fault beats softrst");
    step(1, 2'b11, 0, 0, FS,   0, "R3 softrst in Fail-Safe ignored");
    step(1, 2'b10, 0, 0, FS,   0, "R6 write ignored in Fail-Safe");
    step(0, 2'b00, 1, 1, FS,   0, "R7 fault beats wake");
    step(0, 2'b00, 0, 1, RST,  0, "R8 wake from Fail-Safe");
    step(1, 2'b10, 0, 0, STOP, 0, "R6 Restart to Stop");
    step(1, 2'b00, 1, 0, FS,   0, "R7 fault beats write");
    step(0, 2'b00, 0, 0, FS,   0, "R7 Fail-Safe holds");
    step(0, 2'b00, 0, 0, FS,   0, "R5 idle no reset request");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule